// File: doc/BRIEF.md
# Flash command controller register interface

This block is the register front end and command sequencer of an on-chip nonvolatile memory. A peripheral bus writes a clock divider, a protection mask, a test-mode bit, a target word address, a data word and a command code. Writing a 1 to the buffer-empty status bit then launches the command. While the command runs, a programming-clock enable is derived from the bus clock. When a fixed number of those ticks has elapsed, the command is applied to a behavioural word array held inside the block. Two commands exist: program word and mass erase. Errors and protection hits are reported in write-1-to-clear status flags.

The divider and the protection mask are write-once in normal operation. With `special_mode` high they can be rewritten freely, which lets a host first lift the protection and then reprogram the array. The low byte of the highest array word acts as the security byte. The `secured` output reflects its state.

Register offsets on `bus_addr` are: 0x0 divider, 0x1 protection, 0x2 status, 0x3 command, 0x4 test mode, 0x6 address (16-bit), 0x8 data (16-bit), and 0xA read-only view of the array word at the current address. Status bit 7 is buffer-empty, bit 6 is command-complete, bit 5 is protection violation and bit 4 is access error.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the status register reads 0xC0, protection reads 0xFF, the divider reads 0x00, every array word reads 0xFFFF and `secured` is 1.
- R2: A command keeps status bit 7 low for CMD_TICKS*(D+1) clock cycles, where D is divider bits [5:0]. With divider bit 6 set, that time is multiplied by 8.
- R3: Writing a byte with bit 7 set to the status offset, with a command loaded and the divider written, clears status bits 7 and 6. Both return to 1 together when the command completes.
- R4: Writing 1 to status bit 5 or bit 4 clears that flag. Writing 0 to a flag leaves it unchanged.
- R5: A command write before the divider has been written, a command write with a code other than 0x20 or 0x41, and a launch with no command loaded each set status bit 4 and start nothing (bit 7 stays 1).
- R6: Command 0x20 (program word) replaces the addressed word with the bitwise AND of its old value and the data register.
- R7: Command 0x41 (mass erase) sets every word of the addressed block to 0xFFFF. With test-mode bit 4 set, it erases all blocks.
- R8: A protection bit b equal to 0 protects block b (bit b of the mask, block = upper address bits). A command touching a protected block sets status bit 5 and leaves the array unchanged.
- R9: With `special_mode` low, the divider and protection registers accept only their first write after reset. With `special_mode` high, they accept every write.
- R10: `secured` is 0 only when bits [1:0] of the highest array word equal 2'b10.
- R11: A command write while status bit 7 is 0 sets status bit 4, and the running command is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | Unlocks rewriting of the write-once registers |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| bus_rdata | output | 16 | Read data for the register at `bus_addr` |
| secured | output | 1 | High unless the security byte is in the unsecured state |

## Verification
The hardest situation to reach is a protection violation on an all-block erase after the write-once mask has already been committed. This takes the order divider, array contents, test-mode bit, single mask write, and only then the erase launch. The bench builds that order step by step and then reads back a word from the unprotected block to confirm nothing was erased. The prescaled command time is reached only by entering special mode, which allows the already-locked divider to be rewritten with bit 6 set.

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl #(
  parameter int NBLK      = 2,
  parameter int BLK_WORDS = 16,
  parameter int CMD_TICKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        special_mode,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        secured
);
  localparam int WAW    = $clog2(BLK_WORDS);
  localparam int BAW    = $clog2(NBLK);
  localparam int AW     = WAW + BAW;
  localparam int NWORDS = NBLK * BLK_WORDS;
  localparam int TW     = $clog2(CMD_TICKS + 1);

  localparam logic [3:0] OFS_DIV  = 4'h0;
  localparam logic [3:0] OFS_PROT = 4'h1;
  localparam logic [3:0] OFS_STAT = 4'h2;
  localparam logic [3:0] OFS_CMD  = 4'h3;
  localparam logic [3:0] OFS_TEST = 4'h4;
  localparam logic [3:0] OFS_ADDR = 4'h6;
  localparam logic [3:0] OFS_DATA = 4'h8;
  localparam logic [3:0] OFS_RD   = 4'hA;

  localparam logic [7:0] OP_PROG  = 8'h20;
  localparam logic [7:0] OP_ERASE = 8'h41;

  logic [6:0]    div_q;
  logic          div_done, prot_done;
  logic [7:0]    prot_q, cmd_q;
  logic          all_blk, cmd_ok;
  logic          cbe, cc, pv, ae;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic [15:0]   mem [NWORDS];
  logic [2:0]    pre_cnt;
  logic [5:0]    div_cnt;
  logic [TW-1:0] tk;

  wire busy     = ~cbe;
  wire wr_div   = bus_wr && bus_addr == OFS_DIV;
  wire wr_prot  = bus_wr && bus_addr == OFS_PROT;
  wire wr_stat  = bus_wr && bus_addr == OFS_STAT;
  wire wr_cmd   = bus_wr && bus_addr == OFS_CMD;
  wire wr_test  = bus_wr && bus_addr == OFS_TEST && cbe;
  wire wr_addr  = bus_wr && bus_addr == OFS_ADDR && cbe;
  wire wr_data  = bus_wr && bus_addr == OFS_DATA && cbe;

  wire [BAW-1:0] blk = addr_q[AW-1:WAW];
  wire is_erase   = cmd_q == OP_ERASE;
  wire code_ok    = bus_wdata[7:0] == OP_PROG || bus_wdata[7:0] == OP_ERASE;
  wire cmd_bad    = wr_cmd && (!cbe || !div_done || !code_ok);
  wire viol       = (is_erase && all_blk) ? ~&prot_q[NBLK-1:0] : !prot_q[blk];

  wire launch_req = wr_stat && bus_wdata[7] && cbe;
  wire launch_bad = launch_req && (!cmd_ok || !div_done);
  wire launch_pv  = launch_req && !launch_bad && viol;
  wire launch_go  = launch_req && !launch_bad && !viol;

  wire pre_en = div_q[6] ? (pre_cnt == 3'd7) : 1'b1;
  wire tick   = busy && pre_en && div_cnt == div_q[5:0];
  wire finish = tick && tk == TW'(CMD_TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      div_done  <= 1'b0;
      prot_q    <= 8'hFF;
      prot_done <= 1'b0;
      cmd_q     <= '0;
      cmd_ok    <= 1'b0;
      all_blk   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      cbe       <= 1'b1;
      cc        <= 1'b1;
      pv        <= 1'b0;
      ae        <= 1'b0;
    end else begin
      if (wr_div && (special_mode || !div_done)) begin
        div_q    <= bus_wdata[6:0];
        div_done <= 1'b1;
      end
      if (wr_prot && (special_mode || !prot_done)) begin
        prot_q    <= bus_wdata[7:0];
        prot_done <= 1'b1;
      end
      if (wr_test) all_blk <= bus_wdata[4];
      if (wr_addr) addr_q <= bus_wdata[AW-1:0];
      if (wr_data) data_q <= bus_wdata;
      if (wr_cmd && !cmd_bad) begin
        cmd_q  <= bus_wdata[7:0];
        cmd_ok <= 1'b1;
      end else if (launch_pv || finish) begin
        cmd_ok <= 1'b0;
      end

      if (launch_go) begin
        cbe <= 1'b0;
        cc  <= 1'b0;
      end else if (finish) begin
        cbe <= 1'b1;
        cc  <= 1'b1;
      end

      if (launch_pv)                  pv <= 1'b1;
      else if (wr_stat && bus_wdata[5]) pv <= 1'b0;

      if (launch_bad || cmd_bad)      ae <= 1'b1;
      else if (wr_stat && bus_wdata[4]) ae <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tk      <= '0;
    end else if (launch_go) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tk      <= '0;
    end else if (busy) begin
      pre_cnt <= pre_cnt + 3'd1;
      if (pre_en) div_cnt <= (div_cnt == div_q[5:0]) ? 6'd0 : div_cnt + 6'd1;
      if (tick)   tk <= tk + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= 16'hFFFF;
    end else if (finish) begin
      if (is_erase) begin
        for (int i = 0; i < NWORDS; i++)
          if (all_blk || (i >> WAW) == int'(blk)) mem[i] <= 16'hFFFF;
      end else begin
        mem[addr_q] <= mem[addr_q] & data_q;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DIV:  bus_rdata = {9'd0, div_q};
      OFS_PROT: bus_rdata = {8'd0, prot_q};
      OFS_STAT: bus_rdata = {8'd0, cbe, cc, pv, ae, 4'd0};
      OFS_CMD:  bus_rdata = {8'd0, cmd_q};
      OFS_TEST: bus_rdata = {11'd0, all_blk, 4'd0};
      OFS_ADDR: bus_rdata = 16'(addr_q);
      OFS_DATA: bus_rdata = data_q;
      OFS_RD:   bus_rdata = mem[addr_q];
      default:  bus_rdata = 16'd0;
    endcase
  end

  assign secured = mem[NWORDS-1][1:0] != 2'b10;
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        special_mode,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [7:0]  stat,
  input logic [7:0]  prot_q,
  input logic        prot_done,
  input logic        div_done
);
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[7] |-> !stat[6]); // R3

  AST_FINISH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[7]) |-> stat[6]); // R3

  AST_PROT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h1 && !special_mode && prot_done) |=> $stable(prot_q)); // R9

  AST_NODIV_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h2 && bus_wdata[7] && !div_done && stat[7]) |=> (stat[4] && stat[7])); // R5

  AST_PV_NOLAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[5]) |-> stat[7]); // R8
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat({cbe, cc, pv, ae, 4'd0}),
  .prot_q(prot_q), .prot_done(prot_done), .div_done(div_done)
);

// File: tb/nvm_cmd_ctrl_tb.sv
module nvm_cmd_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, special_mode = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic secured;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nvm_cmd_ctrl u_dut (.clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .secured(secured));

  // {word address[4:0], program data[15:0], expected word[15:0]}
  localparam logic [36:0] VEC [6] = '{
    {5'd3,  16'h1234, 16'h1234},
    {5'd3,  16'hFF0F, 16'h1204},
    {5'd17, 16'hA5A5, 16'hA5A5},
    {5'd17, 16'h0FF0, 16'h05A0},
    {5'd0,  16'h0000, 16'h0000},
    {5'd31, 16'hFFFE, 16'hFFFE}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic wait_done(output int n);
    logic [15:0] s;
    n = 0;
    rd(4'h2, s);
    while (!s[7] && n < 5000) begin
      @(posedge clk); #1;
      n++;
      rd(4'h2, s);
    end
  endtask

  task automatic run(input logic [4:0] a, input logic [15:0] d, input logic [7:0] op, output int n);
    wr(4'h6, 16'(a));
    wr(4'h8, d);
    wr(4'h3, 16'(op));
    wr(4'h2, 16'h0080);
    wait_done(n);
  endtask

  task automatic rd_word(input logic [4:0] a, output logic [15:0] d);
    wr(4'h6, 16'(a));
    rd(4'hA, d);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(4'h2, v); chk("R1 status", v, 16'h00C0);
    rd(4'h1, v); chk("R1 prot", v, 16'h00FF);
    rd(4'h0, v); chk("R1 div", v, 16'h0000);
    rd(4'hA, v); chk("R1 word0", v, 16'hFFFF);
    chk("R1 secured", 16'(secured), 16'h0001);

    wr(4'h2, 16'h0080);
    rd(4'h2, v); chk("R5 launch without divider", v, 16'h00D0);
    wr(4'h2, 16'h0020);
    rd(4'h2, v); chk("R4 zero leaves flag", v, 16'h00D0);
    wr(4'h2, 16'h0010);
    rd(4'h2, v); chk("R4 clear access error", v, 16'h00C0);
    wr(4'h3, 16'h0020);
    rd(4'h2, v); chk("R5 command before divider", v, 16'h00D0);
    wr(4'h2, 16'h0010);

    wr(4'h0, 16'h0001);
    wr(4'h0, 16'h0005);
    rd(4'h0, v); chk("R9 divider write-once", v, 16'h0001);
    wr(4'h2, 16'h0080);
    rd(4'h2, v); chk("R5 launch with no command", v, 16'h00D0);
    wr(4'h2, 16'h0010);
    wr(4'h3, 16'h0033);
    rd(4'h2, v); chk("R5 invalid code", v, 16'h00D0);
    wr(4'h2, 16'h0010);

    wr(4'h6, 16'd5); wr(4'h8, 16'hFFFF); wr(4'h3, 16'h0020);
    wr(4'h2, 16'h0080);
    rd(4'h2, v); chk("R3 launch clears bits 7 and 6", v, 16'h0000);
    wait_done(n);
    chk("R2 command duration 4*(1+1)", 16'(n), 16'd8);
    rd(4'h2, v); chk("R3 completion sets bits 7 and 6", v, 16'h00C0);

    for (int i = 0; i < 6; i++) begin
      run(VEC[i][36:32], VEC[i][31:16], 8'h20, n);
      rd(4'hA, v); chk("R6 program AND", v, VEC[i][15:0]);
    end
    chk("R10 unsecured 0xFE", 16'(secured), 16'h0000);

    run(5'd3, 16'h0000, 8'h41, n);
    rd(4'hA, v); chk("R7 block erase target", v, 16'hFFFF);
    rd_word(5'd17, v); chk("R7 other block kept", v, 16'h05A0);
    wr(4'h4, 16'h0010);
    run(5'd3, 16'h0000, 8'h41, n);
    rd_word(5'd17, v); chk("R7 all-block erase", v, 16'hFFFF);
    chk("R10 erased byte secured", 16'(secured), 16'h0001);
    run(5'd31, 16'hFFFD, 8'h20, n);
    chk("R10 low bits 01 secured", 16'(secured), 16'h0001);

    run(5'd17, 16'h00FF, 8'h20, n);
    wr(4'h1, 16'h00FE);
    wr(4'h1, 16'h00FF);
    rd(4'h1, v); chk("R9 prot write-once", v, 16'h00FE);
    run(5'd3, 16'h0000, 8'h41, n);
    rd(4'h2, v); chk("R8 erase hits protected block", v, 16'h00E0);
    rd_word(5'd17, v); chk("R8 array untouched", v, 16'h00FF);
    wr(4'h2, 16'h0020);
    run(5'd2, 16'h0000, 8'h20, n);
    rd(4'h2, v); chk("R8 program protected block", v, 16'h00E0);
    rd_word(5'd2, v); chk("R8 word kept", v, 16'hFFFF);
    wr(4'h2, 16'h0020);

    wr(4'h6, 16'd20); wr(4'h8, 16'h0000); wr(4'h3, 16'h0020);
    wr(4'h2, 16'h0080);
    wr(4'h3, 16'h0041);
    rd(4'h2, v); chk("R11 command write while busy", v, 16'h0010);
    wait_done(n);
    rd(4'hA, v); chk("R11 running command unaffected", v, 16'h0000);
    rd_word(5'd21, v); chk("R11 no erase", v, 16'hFFFF);
    wr(4'h2, 16'h0010);

    special_mode = 1'b1;
    wr(4'h0, 16'h0040);
    rd(4'h0, v); chk("R9 special divider rewrite", v, 16'h0040);
    wr(4'h1, 16'h00FF);
    rd(4'h1, v); chk("R9 special prot rewrite", v, 16'h00FF);
    run(5'd2, 16'h0F0F, 8'h20, n);
    chk("R2 prescaled duration 4*8*1", 16'(n), 16'd32);
    rd(4'hA, v); chk("R8 unprotected program", v, 16'h0F0F);
    special_mode = 1'b0;

    @(negedge clk) rst_n = 1'b0;
    #7 rst_n = 1'b1;
    rd(4'h2, v); chk("R1 status after reset", v, 16'h00C0);
    rd(4'hA, v); chk("R1 array after reset", v, 16'hFFFF);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule